// File: doc/BRIEF.md
# Tape Mode Control Decoder

This block sits beside a magnetic tape unit's command path and handles the one command that changes how the unit records and reads data: the mode-set control. It takes a one-byte command with a single-cycle strobe and classifies it as a mode set, a status inquiry or something it cannot execute. For a mode set it decodes the byte against the unit type. A seven-track unit takes a density code and one of several parity, translate and converter combinations. A nine-track unit only picks between two densities.

The block holds the resulting mode register. It answers every accepted strobe with a one-cycle status response of channel end, device end and, where warranted, unit check. It also keeps the first sense byte, which records a rejected command or a missing medium. Synchronous reset and a boot pulse both load the mode register with the default for the strapped unit type. Data transfer and tape motion are handled elsewhere.

Top module: `tape_mode_ctl`

## Requirements
- R1: Reset sets the mode to the unit default: on a seven-track unit (`strap_nine`=0) density code 2'b10 (800 bpi), odd parity, converter on and translate off; on a nine-track unit density code 2'b11 (1600 bpi) with all three flags off. Reset also sets `sense0` to 0 and `rsp_valid` to 0.
- R2: A strobe in cycle N (with `boot_init` low) raises `rsp_valid` for exactly the cycle after edge N, always together with `rsp_chan_end` and `rsp_dev_end`. Mode and `sense0` updates become visible in that same cycle.
- R3: A mode set (`cmd_byte[2:0]`=3'b011) on a unit whose `unit_attached` is 0 sets `sense0[6]` (intervention required), answers with unit check and leaves the mode unchanged.
- R4: On a seven-track unit, a mode set with density code `cmd_byte[7:6]`=2'b11 sets `sense0[7]` (command reject), answers with unit check and leaves the mode unchanged.
- R5: On a seven-track unit, a mode set whose control field `cmd_byte[5:3]` is 0, 1 or 3 changes neither the mode nor `sense0`, and answers without unit check.
- R6: On a seven-track unit, a mode set loads the density from `cmd_byte[7:6]`, and its control field sets the flags (parity, translate, converter) as follows: 2 gives odd, off, on; 4 gives even, off, off; 5 gives even, on, off; 6 gives odd, off, off; 7 gives odd, on, off.
- R7: On an attached nine-track unit, a mode set loads density 2'b10 when `cmd_byte[3]` is 1 and 2'b11 when it is 0, for any value of `cmd_byte[7:6]`. It is never rejected, and the three flags keep their value.
- R8: Every mode set that loads the mode clears `sense0` and answers without unit check.
- R9: A status inquiry (`cmd_byte[3:0]`=4'b0000) changes nothing and answers with unit check exactly when `sense0` is nonzero.
- R10: Any other command (neither a mode set nor a status inquiry) sets `sense0[7]`, answers with unit check and leaves the mode unchanged.
- R11: `boot_init` reloads the unit default mode and leaves `sense0` unchanged. A strobe in the same cycle is dropped and gets no response.
- R12: In a cycle without strobe, boot or reset, the mode and `sense0` hold, `rsp_valid` stays low, and `cmd_byte` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_init | input | 1 | Reload the unit default mode |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Command byte |
| strap_nine | input | 1 | 1 = nine-track unit, 0 = seven-track unit |
| unit_attached | input | 1 | Medium present and unit usable |
| mode_density | output | 2 | Density code (00 200, 01 556, 10 800, 11 1600 bpi) |
| mode_odd | output | 1 | Odd parity selected |
| mode_translate | output | 1 | Character translation enabled |
| mode_convert | output | 1 | Data converter enabled |
| rsp_valid | output | 1 | Status response present this cycle |
| rsp_chan_end | output | 1 | Channel end |
| rsp_dev_end | output | 1 | Device end |
| rsp_unit_check | output | 1 | Unit check |
| sense0 | output | 8 | Sense byte 0 (bit 7 reject, bit 6 intervention) |

## Verification
The bench runs a seven-track unit through every control field value, and it orders the commands so that each result depends on the state left by the one before. A decoder that reloaded flags on the no-op fields, or that swapped the parity and translate bits, would leave a wrong mode behind. The density-code-3 case is issued on both unit types: a design that tested the code before checking the unit type would reject a legal nine-track command, and one that skipped the test would load 1600 bpi onto a seven-track unit. Status inquiries are sent both with sense set and with sense clear, which exposes a unit check that is tied high or tied low. A boot pulse that arrives together with a strobe would show up as a stray response or a wiped sense byte.

// File: rtl/tape_mode_pkg.sv
package tape_mode_pkg;

  localparam int CMD_W  = 8;
  localparam int DENS_W = 2;

  // Mode register contents
  typedef struct packed {
    logic [DENS_W-1:0] dens;
    logic              odd;
    logic              trans;
    logic              conv;
  } mode_t;

  // Command classes recognised by the decoder
  typedef enum logic [1:0] {
    OP_STATUS = 2'd0,
    OP_MODE   = 2'd1,
    OP_BAD    = 2'd2
  } op_e;

  // What one decoded command asks of the registers
  typedef struct packed {
    logic  load;       // write next_mode into the mode register
    mode_t next_mode;
    logic  set_rej;    // raise command reject in sense
    logic  set_intv;   // raise intervention required in sense
    logic  clr_sense;  // wipe sense byte
    logic  force_uc;   // unit check regardless of sense
    logic  status_uc;  // unit check if sense is nonzero
  } action_t;

endpackage

// File: rtl/tape_cmd_decode.sv
module tape_cmd_decode
  import tape_mode_pkg::*;
#(
  parameter logic [DENS_W-1:0] NINE_HI_DENS = 2'b10,
  parameter logic [DENS_W-1:0] NINE_LO_DENS = 2'b11
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic             nine,
  input  logic             attached,
  input  mode_t            cur_mode,
  output action_t          act
);

  localparam logic [2:0]        MODE_LOW  = 3'b011;
  localparam logic [3:0]        STAT_LOW  = 4'b0000;
  localparam logic [DENS_W-1:0] DENS_BAD7 = '1;

  op_e              op;
  logic [2:0]       field;
  logic [DENS_W-1:0] dcode;

  assign field = cmd[5:3];
  assign dcode = cmd[7:6];

  always_comb begin
    if (cmd[2:0] == MODE_LOW)      op = OP_MODE;
    else if (cmd[3:0] == STAT_LOW) op = OP_STATUS;
    else                           op = OP_BAD;
  end

  always_comb begin
    act           = '0;
    act.next_mode = cur_mode;
    unique case (op)
      OP_STATUS: act.status_uc = 1'b1;
      OP_MODE: begin
        if (!attached) begin
          act.set_intv = 1'b1;
          act.force_uc = 1'b1;
        end else if (nine) begin
          // only density matters on nine-track units
          act.load           = 1'b1;
          act.clr_sense      = 1'b1;
          act.next_mode.dens = cmd[3] ? NINE_HI_DENS : NINE_LO_DENS;
        end else if (dcode == DENS_BAD7) begin
          act.set_rej  = 1'b1;
          act.force_uc = 1'b1;
        end else begin
          unique case (field)
            3'd0, 3'd1, 3'd3: begin
              // no-op fields: nothing loaded, sense untouched
            end
            3'd2: begin
              act.load            = 1'b1;
              act.clr_sense       = 1'b1;
              act.next_mode.dens  = dcode;
              act.next_mode.odd   = 1'b1;
              act.next_mode.trans = 1'b0;
              act.next_mode.conv  = 1'b1;
            end
            default: begin
              // fields 4..7: bit 1 picks parity, bit 0 picks translate
              act.load            = 1'b1;
              act.clr_sense       = 1'b1;
              act.next_mode.dens  = dcode;
              act.next_mode.odd   = field[1];
              act.next_mode.trans = field[0];
              act.next_mode.conv  = 1'b0;
            end
          endcase
        end
      end
      default: begin
        act.set_rej  = 1'b1;
        act.force_uc = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tape_mode_reg.sv
module tape_mode_reg
  import tape_mode_pkg::*;
#(
  parameter logic [DENS_W-1:0] DEF_DENS_7 = 2'b10,
  parameter logic [DENS_W-1:0] DEF_DENS_9 = 2'b11
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  boot,
  input  logic  nine,
  input  logic  load,
  input  mode_t next_mode,
  output mode_t mode_q
);

  mode_t dflt;

  always_comb begin
    dflt.dens  = nine ? DEF_DENS_9 : DEF_DENS_7;
    dflt.odd   = !nine;
    dflt.trans = 1'b0;
    dflt.conv  = !nine;
  end

  always_ff @(posedge clk) begin
    if (rst || boot) mode_q <= dflt;
    else if (load)   mode_q <= next_mode;
  end

endmodule

// File: rtl/tape_rsp_sense.sv
module tape_rsp_sense
  import tape_mode_pkg::*;
#(
  parameter int SNS_W    = 8,
  parameter int REJ_BIT  = 7,
  parameter int INTV_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  action_t          act,
  output logic             rsp_valid,
  output logic             rsp_ce,
  output logic             rsp_de,
  output logic             rsp_uc,
  output logic [SNS_W-1:0] sense_q
);

  logic [SNS_W-1:0] set_mask;
  logic [SNS_W-1:0] sense_nxt;
  logic             uc_nxt;

  always_comb begin
    set_mask           = '0;
    set_mask[REJ_BIT]  = act.set_rej;
    set_mask[INTV_BIT] = act.set_intv;
    sense_nxt          = act.clr_sense ? '0 : (sense_q | set_mask);
    uc_nxt             = act.force_uc | (act.status_uc & (|sense_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ce    <= 1'b0;
      rsp_de    <= 1'b0;
      rsp_uc    <= 1'b0;
      sense_q   <= '0;
    end else begin
      rsp_valid <= take;
      rsp_ce    <= take;
      rsp_de    <= take;
      rsp_uc    <= take & uc_nxt;
      if (take) sense_q <= sense_nxt;
    end
  end

endmodule

// File: rtl/tape_mode_ctl.sv
module tape_mode_ctl
  import tape_mode_pkg::*;
#(
  parameter int                SNS_W      = 8,
  parameter int                REJ_BIT    = 7,
  parameter int                INTV_BIT   = 6,
  parameter logic [DENS_W-1:0] DEF_DENS_7 = 2'b10,
  parameter logic [DENS_W-1:0] DEF_DENS_9 = 2'b11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_init,
  input  logic             cmd_stb,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             strap_nine,
  input  logic             unit_attached,
  output logic [DENS_W-1:0] mode_density,
  output logic             mode_odd,
  output logic             mode_translate,
  output logic             mode_convert,
  output logic             rsp_valid,
  output logic             rsp_chan_end,
  output logic             rsp_dev_end,
  output logic             rsp_unit_check,
  output logic [SNS_W-1:0] sense0
);

  // nine-track densities: bit 3 set picks the lower of the two
  localparam logic [DENS_W-1:0] NINE_HI = 2'b10;
  localparam logic [DENS_W-1:0] NINE_LO = 2'b11;

  mode_t   mode_q;
  action_t act;
  logic    take;

  assign take = cmd_stb & ~boot_init;

  tape_cmd_decode #(
    .NINE_HI_DENS(NINE_HI),
    .NINE_LO_DENS(NINE_LO)
  ) u_dec (
    .cmd      (cmd_byte),
    .nine     (strap_nine),
    .attached (unit_attached),
    .cur_mode (mode_q),
    .act      (act)
  );

  tape_mode_reg #(
    .DEF_DENS_7(DEF_DENS_7),
    .DEF_DENS_9(DEF_DENS_9)
  ) u_mode (
    .clk       (clk),
    .rst       (rst),
    .boot      (boot_init),
    .nine      (strap_nine),
    .load      (take & act.load),
    .next_mode (act.next_mode),
    .mode_q    (mode_q)
  );

  tape_rsp_sense #(
    .SNS_W   (SNS_W),
    .REJ_BIT (REJ_BIT),
    .INTV_BIT(INTV_BIT)
  ) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .act      (act),
    .rsp_valid(rsp_valid),
    .rsp_ce   (rsp_chan_end),
    .rsp_de   (rsp_dev_end),
    .rsp_uc   (rsp_unit_check),
    .sense_q  (sense0)
  );

  assign mode_density   = mode_q.dens;
  assign mode_odd       = mode_q.odd;
  assign mode_translate = mode_q.trans;
  assign mode_convert   = mode_q.conv;

endmodule

// File: rtl/tape_mode_ctl_chk.sv
module tape_mode_ctl_chk #(
  parameter int SNS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             boot_init,
  input logic             cmd_stb,
  input logic             strap_nine,
  input logic [1:0]       mode_density,
  input logic             mode_odd,
  input logic             mode_translate,
  input logic             mode_convert,
  input logic             rsp_valid,
  input logic             rsp_chan_end,
  input logic             rsp_dev_end,
  input logic             rsp_unit_check,
  input logic [SNS_W-1:0] sense0
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sense0 == '0) && !rsp_valid);

  // R2
  resp_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(cmd_stb && !boot_init && !rst));

  // R2
  resp_ends_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_chan_end && rsp_dev_end);

  // R2
  no_stray_check_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_unit_check && !rsp_chan_end && !rsp_dev_end);

  // R10
  new_sense_checks_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_valid && ((sense0 & ~$past(sense0)) != '0)) |-> rsp_unit_check);

  // R8
  load_clears_sense_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(boot_init) &&
     !$stable({mode_density, mode_odd, mode_translate, mode_convert}))
    |-> rsp_valid && (sense0 == '0) && !rsp_unit_check);

  // R7
  nine_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(boot_init) && $past(strap_nine))
    |-> $stable({mode_odd, mode_translate, mode_convert}));

  // R11
  boot_drops_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $past(boot_init) |-> !rsp_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(boot_init) && !$past(cmd_stb))
    |-> $stable({mode_density, mode_odd, mode_translate, mode_convert, sense0}));

endmodule

bind tape_mode_ctl tape_mode_ctl_chk #(.SNS_W(SNS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .boot_init     (boot_init),
  .cmd_stb       (cmd_stb),
  .strap_nine    (strap_nine),
  .mode_density  (mode_density),
  .mode_odd      (mode_odd),
  .mode_translate(mode_translate),
  .mode_convert  (mode_convert),
  .rsp_valid     (rsp_valid),
  .rsp_chan_end  (rsp_chan_end),
  .rsp_dev_end   (rsp_dev_end),
  .rsp_unit_check(rsp_unit_check),
  .sense0        (sense0)
);

// File: tb/tape_mode_ctl_bench.sv
`timescale 1ns/1ps
module tape_mode_ctl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_init = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       strap_nine = 1'b0;
  logic       unit_attached = 1'b1;
  logic [1:0] mode_density;
  logic       mode_odd, mode_translate, mode_convert;
  logic       rsp_valid, rsp_chan_end, rsp_dev_end, rsp_unit_check;
  logic [7:0] sense0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tape_mode_ctl u_tape_mode_ctl (
    .clk(clk), .rst(rst), .boot_init(boot_init), .cmd_stb(cmd_stb),
    .cmd_byte(cmd_byte), .strap_nine(strap_nine), .unit_attached(unit_attached),
    .mode_density(mode_density), .mode_odd(mode_odd),
    .mode_translate(mode_translate), .mode_convert(mode_convert),
    .rsp_valid(rsp_valid), .rsp_chan_end(rsp_chan_end),
    .rsp_dev_end(rsp_dev_end), .rsp_unit_check(rsp_unit_check),
    .sense0(sense0)
  );

  // {attached, cmd, density, odd, translate, convert, unit check, sense0}
  localparam int NV = 16;
  localparam logic [22:0] VECS [NV] = '{
    {1'b1, 8'h23, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h6B, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hB3, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h3B, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h53, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'hC3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80},
    {1'b1, 8'h00, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80},
    {1'b1, 8'h03, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80},
    {1'b1, 8'h8B, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80},
    {1'b1, 8'h1B, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80},
    {1'b0, 8'h23, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC0},
    {1'b1, 8'h02, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC0},
    {1'b1, 8'hA3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h0F, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80},
    {1'b1, 8'hFB, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80}
  };
  string vtag [NV] = '{"R6", "R6", "R6", "R6", "R6", "R4", "R9", "R5",
                       "R5", "R5", "R3", "R10", "R8", "R9", "R10", "R4"};

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_mode(input string tag, input logic [1:0] d,
                          input logic o, input logic t, input logic c);
    chk(tag, "density", 32'(mode_density), 32'(d));
    chk(tag, "odd", 32'(mode_odd), 32'(o));
    chk(tag, "translate", 32'(mode_translate), 32'(t));
    chk(tag, "convert", 32'(mode_convert), 32'(c));
  endtask

  task automatic do_reset(input logic nine);
    @(negedge clk);
    strap_nine = nine;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // strobe at one edge; returns at the next falling edge with results visible
  task automatic issue(input logic att, input logic [7:0] c);
    @(negedge clk);
    unit_attached = att;
    cmd_byte = c;
    cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 seven-track reset state
    do_reset(1'b0);
    chk_mode("R1", 2'b10, 1'b1, 1'b0, 1'b1);
    chk("R1", "sense0", 32'(sense0), 32'h00);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'h0);

    // table walk, seven-track; each entry builds on the previous state
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VECS[i];
      issue(v[22], v[21:14]);
      chk(vtag[i], "rsp_valid", 32'(rsp_valid), 32'h1);
      chk(vtag[i], "chan_end", 32'(rsp_chan_end), 32'h1);
      chk(vtag[i], "dev_end", 32'(rsp_dev_end), 32'h1);
      chk(vtag[i], "unit_check", 32'(rsp_unit_check), 32'(v[8]));
      chk_mode(vtag[i], v[13:12], v[11], v[10], v[9]);
      chk(vtag[i], "sense0", 32'(sense0), 32'(v[7:0]));
    end

    // R2 response lasts one cycle
    @(negedge clk);
    chk("R2", "rsp_valid second cycle", 32'(rsp_valid), 32'h0);

    // R12 idle with a changing command byte: nothing moves
    cmd_byte = 8'h23;
    repeat (2) @(negedge clk);
    cmd_byte = 8'hC3;
    repeat (2) @(negedge clk);
    chk("R12", "rsp_valid", 32'(rsp_valid), 32'h0);
    chk_mode("R12", 2'b10, 1'b0, 1'b0, 1'b0);
    chk("R12", "sense0", 32'(sense0), 32'h80);

    // R11 boot with a simultaneous strobe: default mode, sense kept, no response
    @(negedge clk);
    boot_init = 1'b1;
    cmd_byte = 8'h23;
    cmd_stb = 1'b1;
    @(negedge clk);
    boot_init = 1'b0;
    cmd_stb = 1'b0;
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'h0);
    chk_mode("R11", 2'b10, 1'b1, 1'b0, 1'b1);
    chk("R11", "sense0", 32'(sense0), 32'h80);

    // R1 nine-track reset state
    do_reset(1'b1);
    chk_mode("R1", 2'b11, 1'b0, 1'b0, 1'b0);
    chk("R1", "sense0", 32'(sense0), 32'h00);

    // R7 bit 3 set picks 800
    issue(1'b1, 8'h0B);
    chk_mode("R7", 2'b10, 1'b0, 1'b0, 1'b0);
    chk("R7", "unit_check", 32'(rsp_unit_check), 32'h0);

    // R7 density code 11 accepted on nine-track, bit 3 clear picks 1600
    issue(1'b1, 8'hC3);
    chk_mode("R7", 2'b11, 1'b0, 1'b0, 1'b0);
    chk("R7", "unit_check", 32'(rsp_unit_check), 32'h0);
    chk("R7", "sense0", 32'(sense0), 32'h00);

    // R7 flag-setting field ignored on nine-track
    issue(1'b1, 8'h3B);
    chk_mode("R7", 2'b10, 1'b0, 1'b0, 1'b0);

    // R3 unattached nine-track unit
    issue(1'b0, 8'h03);
    chk("R3", "unit_check", 32'(rsp_unit_check), 32'h1);
    chk("R3", "sense0", 32'(sense0), 32'h40);
    chk_mode("R3", 2'b10, 1'b0, 1'b0, 1'b0);

    // R9 status with sense set on nine-track, then R8 clear by mode set
    issue(1'b1, 8'h00);
    chk("R9", "unit_check", 32'(rsp_unit_check), 32'h1);
    issue(1'b1, 8'h03);
    chk("R8", "sense0", 32'(sense0), 32'h00);
    chk("R8", "unit_check", 32'(rsp_unit_check), 32'h0);
    chk_mode("R8", 2'b11, 1'b0, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule